// File: doc/BRIEF.md
# Bit-Enable Accumulator Processor

This block is a compact 8-bit accumulator processor with separate program and data storage. A single program counter indexes both stores in the same step, so every instruction byte is paired with the operand byte held at the same index. The instruction byte has no opcode table. Its low bits drive the datapath controls directly: the operand-register load, the accumulator load, subtract mode, the data-store write, the result selector and the counter preset. Conditional and unconditional jumps are distinguished only by combining the preset bit with the selector bit.

Each instruction completes in one clock cycle. Software fills both stores through a load port while reset is held. After reset is released the core runs from index 0 until it fetches an all-zero byte, then stays halted until the next reset. The accumulator, the program counter, the zero flag, the last executed instruction and a per-step strobe are brought out so that an execution trace can be compared against an expected one.

Top module: `bitctl_cpu`

## Requirements
- R1: In each step the program counter value addresses both stores. The instruction byte and the operand byte are taken from that same index.
- R2: Instruction bit 0 selects the accumulator's next value source: 1 selects the adder result and 0 selects the operand register. Bit 2 sets subtract mode, which gives accumulator minus operand. Otherwise the result is accumulator plus operand. Results wrap modulo 256 and the carry-in is zero.
- R3: Bit 4 loads the operand register from the data byte at the current index, and bit 3 loads the accumulator from the selected result. A register whose bit is clear keeps its value.
- R4: Bit 1 writes the accumulator value produced by this step into the data store at the current index.
- R5: After each executed step, `zero_out` is 1 exactly when the accumulator equals zero.
- R6: If bit 5, bit 0 and the new zero flag are all 1, the program counter loads the operand register value for this step.
- R7: If bit 5 is 1 and bit 0 is 0, the program counter loads the operand register value regardless of the zero flag.
- R8: In all other cases the program counter increments by one, and this includes bit 5 set with bit 0 set and a nonzero accumulator.
- R9: Fetching the byte 0x00 sets `halted` and changes no other state. `halted` stays 1, and the program counter and accumulator stay frozen, until reset.
- R10: A synchronous active-high reset clears the program counter, all registers, the zero flag and `halted`. While reset is held, a cycle with `ld_en` high writes `ld_data` at `ld_addr` into the program store when `ld_sel` is 0, or into the data store when `ld_sel` is 1.
- R11: `step_valid` is high for one cycle after each executed (non-halt) step. `acc_out` then shows the accumulator value after that step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| ld_en | input | 1 | Store write strobe, honoured only during reset |
| ld_sel | input | 1 | Target store: 0 program, 1 data |
| ld_addr | input | 8 | Store index for a load |
| ld_data | input | 8 | Byte to load |
| pc_out | output | 8 | Current program counter |
| acc_out | output | 8 | Accumulator |
| ir_out | output | 8 | Last executed instruction byte |
| zero_out | output | 1 | Zero flag from the last step |
| step_valid | output | 1 | One-cycle pulse after each executed step |
| halted | output | 1 | Sticky halt indication |

## Verification
Several programs are loaded and their accumulator traces are compared step by step. A countdown loop with a conditional exit tells a taken jump-if-zero apart from an untaken one, and it also checks the unconditional back-jump. A self-accumulating loop stores into the location it reads back on its next pass, so its trace doubles only if the write really landed. A wrap program and a register-hold program cover modulo-256 arithmetic and the independence of the two load enables. A halt check after the first program confirms that the counter and accumulator stay frozen.

// File: rtl/bitctl_pkg.sv
package bitctl_pkg;

    localparam int unsigned WORD_W = 8;
    localparam int unsigned IDX_W  = 8;

    // Control bit positions inside an instruction byte
    localparam int unsigned B_SEL    = 0;
    localparam int unsigned B_WRMEM  = 1;
    localparam int unsigned B_SUB    = 2;
    localparam int unsigned B_LDACC  = 3;
    localparam int unsigned B_LDOPND = 4;
    localparam int unsigned B_PRESET = 5;

    typedef struct packed {
        logic preset;
        logic ld_opnd;
        logic ld_acc;
        logic sub;
        logic wr_mem;
        logic sel_sum;
    } ctl_t;

    function automatic ctl_t decode_ctl(input logic [WORD_W-1:0] ins);
        ctl_t c;
        c.preset  = ins[B_PRESET];
        c.ld_opnd = ins[B_LDOPND];
        c.ld_acc  = ins[B_LDACC];
        c.sub     = ins[B_SUB];
        c.wr_mem  = ins[B_WRMEM];
        c.sel_sum = ins[B_SEL];
        return c;
    endfunction

endpackage

// File: rtl/bitctl_store.sv
module bitctl_store #(
    parameter int unsigned DW = 8,
    parameter int unsigned AW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int unsigned DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];

endmodule

// File: rtl/bitctl_alu.sv
module bitctl_alu #(
    parameter int unsigned DW = 8
) (
    input  logic [DW-1:0] acc,
    input  logic [DW-1:0] opnd,
    input  logic          sub,
    input  logic          sel_sum,
    output logic [DW-1:0] res
);
    logic [DW-1:0] sum_w;

    always_comb begin
        if (sub) begin
            sum_w = acc - opnd;
        end else begin
            sum_w = acc + opnd;
        end
        res = sel_sum ? sum_w : opnd;
    end

endmodule

// File: rtl/bitctl_cpu.sv
module bitctl_cpu
    import bitctl_pkg::*;
#(
    parameter int unsigned DW = WORD_W,
    parameter int unsigned AW = IDX_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ld_en,
    input  logic          ld_sel,
    input  logic [AW-1:0] ld_addr,
    input  logic [DW-1:0] ld_data,
    output logic [AW-1:0] pc_out,
    output logic [DW-1:0] acc_out,
    output logic [DW-1:0] ir_out,
    output logic          zero_out,
    output logic          step_valid,
    output logic          halted
);

    typedef struct packed {
        logic [AW-1:0] pc;
        logic [DW-1:0] ir;
        logic [DW-1:0] opnd;
        logic [DW-1:0] acc;
        logic          zf;
        logic          halt;
        logic          sv;
    } core_t;

    core_t st_d, st_q;

    logic [DW-1:0] ins_w, dat_w, res_w, opnd_new, acc_new;
    logic          zf_new, take_jmp, run_wr;
    ctl_t          ctl_w;

    logic          p_we, d_we;
    logic [AW-1:0] d_waddr;
    logic [DW-1:0] d_wdata;

    bitctl_store #(.DW(DW), .AW(AW)) u_prog (
        .clk   (clk),
        .we    (p_we),
        .waddr (ld_addr),
        .wdata (ld_data),
        .raddr (st_q.pc),
        .rdata (ins_w)
    );

    bitctl_store #(.DW(DW), .AW(AW)) u_data (
        .clk   (clk),
        .we    (d_we),
        .waddr (d_waddr),
        .wdata (d_wdata),
        .raddr (st_q.pc),
        .rdata (dat_w)
    );

    bitctl_alu #(.DW(DW)) u_alu (
        .acc     (st_q.acc),
        .opnd    (opnd_new),
        .sub     (ctl_w.sub),
        .sel_sum (ctl_w.sel_sum),
        .res     (res_w)
    );

    always_comb begin
        ctl_w    = decode_ctl(ins_w);
        opnd_new = ctl_w.ld_opnd ? dat_w : st_q.opnd;
        acc_new  = ctl_w.ld_acc ? res_w : st_q.acc;
        zf_new   = (acc_new == '0);
        take_jmp = ctl_w.preset & (~ctl_w.sel_sum | zf_new);
        run_wr   = ~rst & ~st_q.halt & (ins_w != '0) & ctl_w.wr_mem;

        st_d    = st_q;
        st_d.sv = 1'b0;
        if (!st_q.halt) begin
            if (ins_w == '0) begin
                st_d.halt = 1'b1;
            end else begin
                st_d.ir   = ins_w;
                st_d.opnd = opnd_new;
                st_d.acc  = acc_new;
                st_d.zf   = zf_new;
                st_d.sv   = 1'b1;
                st_d.pc   = take_jmp ? opnd_new[AW-1:0] : st_q.pc + 1'b1;
            end
        end

        p_we    = rst & ld_en & ~ld_sel;
        d_we    = (rst & ld_en & ld_sel) | run_wr;
        d_waddr = rst ? ld_addr : st_q.pc;
        d_wdata = rst ? ld_data : acc_new;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pc_out     = st_q.pc;
    assign acc_out    = st_q.acc;
    assign ir_out     = st_q.ir;
    assign zero_out   = st_q.zf;
    assign step_valid = st_q.sv;
    assign halted     = st_q.halt;

endmodule

module bitctl_cpu_chk #(
    parameter int unsigned DW = 8,
    parameter int unsigned AW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic [DW-1:0] ins,
    input logic [AW-1:0] pc_out,
    input logic [DW-1:0] acc_out,
    input logic          zero_out,
    input logic          step_valid,
    input logic          halted
);
    import bitctl_pkg::*;

    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (pc_out == '0 && acc_out == '0 && !halted && !step_valid)); // R10

    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (rst)
        halted |=> halted); // R9

    AST_HALT_FROZEN: assert property (@(posedge clk) disable iff (rst)
        halted |=> ($stable(pc_out) && $stable(acc_out) && !step_valid)); // R9

    AST_HALT_ENTRY: assert property (@(posedge clk) disable iff (rst)
        (!halted && ins == '0) |=> (halted && $stable(pc_out) && $stable(acc_out))); // R9

    AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (rst)
        step_valid |-> (zero_out == (acc_out == '0))); // R5

    AST_PC_INCR: assert property (@(posedge clk) disable iff (rst)
        (!halted && ins != '0 && !ins[B_PRESET]) |=> (pc_out == AW'($past(pc_out) + 1'b1))); // R8

    AST_STEP_PULSE: assert property (@(posedge clk) disable iff (rst)
        (!halted && ins != '0) |=> step_valid); // R11

endmodule

bind bitctl_cpu bitctl_cpu_chk #(.DW(DW), .AW(AW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .ins        (ins_w),
    .pc_out     (pc_out),
    .acc_out    (acc_out),
    .zero_out   (zero_out),
    .step_valid (step_valid),
    .halted     (halted)
);

// File: tb/bitctl_cpu_tb.sv
module bitctl_cpu_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ld_en = 1'b0;
    logic       ld_sel = 1'b0;
    logic [7:0] ld_addr = '0;
    logic [7:0] ld_data = '0;
    logic [7:0] pc_out, acc_out, ir_out;
    logic       zero_out, step_valid, halted;

    int n_run = 0;
    int n_fail = 0;
    int got [64];
    int n_got;

    always #2 clk = ~clk;

    bitctl_cpu u_dut (
        .clk        (clk),
        .rst        (rst),
        .ld_en      (ld_en),
        .ld_sel     (ld_sel),
        .ld_addr    (ld_addr),
        .ld_data    (ld_data),
        .pc_out     (pc_out),
        .acc_out    (acc_out),
        .ir_out     (ir_out),
        .zero_out   (zero_out),
        .step_valid (step_valid),
        .halted     (halted)
    );

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic enter_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
    endtask

    task automatic put(input logic sel, input int a, input int v);
        ld_en   = 1'b1;
        ld_sel  = sel;
        ld_addr = a[7:0];
        ld_data = v[7:0];
        @(negedge clk);
        ld_en   = 1'b0;
    endtask

    // Release reset and record acc_out for each step_valid over ncyc cycles
    task automatic run_trace(input int ncyc);
        n_got = 0;
        rst = 1'b0;
        for (int i = 0; i < ncyc; i++) begin
            @(negedge clk);
            if (step_valid && n_got < 64) begin
                got[n_got] = int'(acc_out);
                n_got++;
            end
        end
    endtask

    task automatic t_reset();
        enter_reset();
        @(negedge clk);
        check("R10 pc", int'(pc_out), 0);
        check("R10 acc", int'(acc_out), 0);
        check("R10 halted", int'(halted), 0);
        check("R10 step_valid", int'(step_valid), 0);
    endtask

    // Load, add, subtract loop with jz/jmp; ends in halt
    task automatic t_example();
        int exp_v [17] = '{10,12,9,9,9,9,6,6,6,6,3,3,3,3,0,0,0};
        int pr [7] = '{8'h18, 8'h19, 8'h1D, 8'h02, 8'h31, 8'h30, 8'h00};
        int dt [6] = '{10, 2, 3, 8'hFF, 6, 2};
        enter_reset();
        for (int i = 0; i < 7; i++) put(1'b0, i, pr[i]);
        for (int i = 0; i < 6; i++) put(1'b1, i, dt[i]);
        run_trace(30);
        check("R11 step count", n_got, 17);
        for (int i = 0; i < 17; i++) check("R1/R2/R6/R7/R8 trace", got[i], exp_v[i]);
        check("R9 halted", int'(halted), 1);
        check("R6 pc at halt", int'(pc_out), 6);
        check("R5 zero flag", int'(zero_out), 1);
        check("R9 ir keeps last executed", int'(ir_out), 8'h31);
        repeat (5) @(negedge clk);
        check("R9 still halted", int'(halted), 1);
        check("R9 pc frozen", int'(pc_out), 6);
        check("R9 acc frozen", int'(acc_out), 0);
        check("R9 no step", int'(step_valid), 0);
    endtask

    // Countdown by one: jz not taken until acc reaches zero
    task automatic t_countdown();
        int exp_v [15] = '{5,4,4,4,3,3,3,2,2,2,1,1,1,0,0};
        int pr [5] = '{8'h18, 8'h1D, 8'h31, 8'h30, 8'h00};
        int dt [4] = '{5, 1, 4, 1};
        enter_reset();
        check("R10 halted cleared", int'(halted), 0);
        for (int i = 0; i < 5; i++) put(1'b0, i, pr[i]);
        for (int i = 0; i < 4; i++) put(1'b1, i, dt[i]);
        run_trace(25);
        check("R11 step count", n_got, 15);
        for (int i = 0; i < 15; i++) check("R6/R8 countdown trace", got[i], exp_v[i]);
        check("R6 pc at halt", int'(pc_out), 4);
    endtask

    // Store into the slot that is read back on the next loop pass
    task automatic t_store();
        int exp_v [8] = '{10,13,13,26,26,52,52,104};
        enter_reset();
        put(1'b0, 0, 8'h18); put(1'b0, 1, 8'h1B); put(1'b0, 2, 8'h30);
        put(1'b1, 0, 10);    put(1'b1, 1, 3);     put(1'b1, 2, 1);
        run_trace(8);
        check("R4 step count", n_got, 8);
        for (int i = 0; i < 8; i++) check("R4 store trace", got[i], exp_v[i]);
    endtask

    // Modulo-256 subtract and add
    task automatic t_wrap();
        enter_reset();
        put(1'b0, 0, 8'h18); put(1'b0, 1, 8'h1D); put(1'b0, 2, 8'h19); put(1'b0, 3, 8'h00);
        put(1'b1, 0, 2);     put(1'b1, 1, 5);     put(1'b1, 2, 250);
        rst = 1'b0;
        @(negedge clk);
        check("R2 load", int'(acc_out), 2);
        @(negedge clk);
        check("R2 sub wraps", int'(acc_out), 253);
        check("R5 nonzero flag", int'(zero_out), 0);
        @(negedge clk);
        check("R2 add wraps", int'(acc_out), 247);
        repeat (2) @(negedge clk);
        check("R9 halted", int'(halted), 1);
    endtask

    // Independent load enables: clear enable keeps the register
    task automatic t_hold();
        int exp_v [4] = '{7,7,99,198};
        enter_reset();
        put(1'b0, 0, 8'h18); put(1'b0, 1, 8'h10); put(1'b0, 2, 8'h08);
        put(1'b0, 3, 8'h09); put(1'b0, 4, 8'h00);
        put(1'b1, 0, 7); put(1'b1, 1, 99); put(1'b1, 2, 55); put(1'b1, 3, 1);
        run_trace(8);
        check("R3 step count", n_got, 4);
        for (int i = 0; i < 4; i++) check("R3 hold trace", got[i], exp_v[i]);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_example();
        t_countdown();
        t_store();
        t_wrap();
        t_hold();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule